// File: doc/BRIEF.md
# Effective Address Unit

This unit turns a register-based operand specifier into an address for a 32-bit load/store processor with sixteen general registers. Each cycle it looks at a mode code, a register index and an operand size, reads the selected base register from a register file held inside the unit, and presents the effective address at once, combinationally. A separate flag tells the load/store stage that the operand is a register and that no memory access is needed.

The two auto-modifying modes move the base register by the operand width. Post-increment hands out the old value as the address and stores the advanced value. Pre-decrement steps the register back first and uses the stepped value for both the address and the stored result. The updated base leaves the unit on a write-back port and is committed into the internal register file on the clock edge when the execute strobe is high. A separate load port lets the rest of the pipeline set registers. When both touch the same register in the same cycle, the auto-update takes priority.

Top module: `eag_unit`

## Requirements
- R1: Mode code 00 (register direct) drives the selected register's contents on `ea_o`, raises `reg_op_o` and never raises `wb_en_o`.
- R2: Mode code 01 (register indirect) drives the selected register's contents on `ea_o`, keeps `reg_op_o` low, never raises `wb_en_o` and leaves the register unchanged.
- R3: With mode code 10 (post-increment) and `exec_i` high, `ea_o` is the register value before the edge. `wb_en_o` is high, `wb_idx_o` equals `idx_i`, and `wb_data_o` is that value plus the size step. After the edge the register holds `wb_data_o`.
- R4: With mode code 11 (pre-decrement) and `exec_i` high, `ea_o` and `wb_data_o` both equal the register value minus the size step. `wb_en_o` is high, and after the edge the register holds that value.
- R5: The size step is 1 for size code 00 (byte), 2 for 01 (word) and 4 for 10 (longword). Code 11 steps by 4.
- R6: Address arithmetic wraps modulo 2^32: incrementing 0xFFFFFFFF by 4 gives 0x00000003, and decrementing 0x00000001 by 4 gives 0xFFFFFFFD.
- R7: While `exec_i` is low, `wb_en_o` stays low and no register is modified by any mode.
- R8: A clock edge with `rst` high clears all sixteen registers to zero.
- R9: A clock edge with `ld_en_i` high writes `ld_data_i` into register `ld_idx_i`. If an auto-update targets the same register in that cycle, the auto-update value is stored and the load is dropped. A load to a different register in that cycle still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| exec_i | input | 1 | Execute strobe; commits auto-updates on the edge |
| mode_i | input | 2 | Addressing mode code |
| idx_i | input | 4 | Base register index |
| size_i | input | 2 | Operand size code |
| ld_en_i | input | 1 | Register load enable |
| ld_idx_i | input | 4 | Register load index |
| ld_data_i | input | 32 | Register load value |
| ea_o | output | 32 | Effective address (the operand itself in direct mode) |
| reg_op_o | output | 1 | High when the operand is a register, not memory |
| wb_en_o | output | 1 | Base register write-back valid |
| wb_idx_o | output | 4 | Write-back register index |
| wb_data_o | output | 32 | Updated base register value |

## Verification
The bench runs chained post-increments and pre-decrements through all four size codes on one register. A wrong step or a missing commit therefore shows up as a drifting address in later vectors. If a design swaps the order of use and update, it gives the adjusted value as the address for post-increment, or the old value for pre-decrement. The bench also targets 32-bit wrap in both directions and a size code of 11 that must step by four. It checks a strobe-low cycle that must not write, and a collision between a load and an auto-update, where a wrong priority leaves the loaded value in place of the stepped one.

// File: rtl/eag_pkg.sv
package eag_pkg;
   typedef enum logic [1:0] {
      AM_REG     = 2'b00,
      AM_IND     = 2'b01,
      AM_POSTINC = 2'b10,
      AM_PREDEC  = 2'b11
   } am_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_FULL = 2'b10,
      SZ_RSVD = 2'b11
   } osz_e;
endpackage

// File: rtl/eag_step.sv
module eag_step #(
   parameter int DW         = 32,
   parameter int STEP_STYLE = 0
) (
   input  logic [1:0]    size_i,
   output logic [DW-1:0] step_o
);
   import eag_pkg::*;

   generate
      if (STEP_STYLE == 0) begin : g_shift
         logic [1:0] sh;
         always_comb begin
            sh     = (size_i == SZ_RSVD) ? 2'd2 : size_i;
            step_o = {{(DW-1){1'b0}}, 1'b1} << sh;
         end
      end else begin : g_mux
         always_comb begin
            unique case (osz_e'(size_i))
               SZ_BYTE: step_o = DW'(1);
               SZ_HALF: step_o = DW'(2);
               default: step_o = DW'(4);
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/eag_calc.sv
module eag_calc #(
   parameter int DW           = 32,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [1:0]    mode_i,
   input  logic [DW-1:0] base_i,
   input  logic [DW-1:0] step_i,
   output logic [DW-1:0] ea_o,
   output logic [DW-1:0] next_o,
   output logic          modify_o,
   output logic          reg_op_o
);
   import eag_pkg::*;

   logic is_pre;
   assign is_pre   = (am_e'(mode_i) == AM_PREDEC);
   assign modify_o = (am_e'(mode_i) == AM_POSTINC) || is_pre;
   assign reg_op_o = (am_e'(mode_i) == AM_REG);

   generate
      if (SHARED_ADDER) begin : g_one_add
         logic [DW-1:0] offs;
         logic [DW-1:0] sum;
         always_comb begin
            offs   = is_pre ? (~step_i + DW'(1)) : step_i;
            sum    = base_i + offs;
            ea_o   = is_pre ? sum : base_i;
            next_o = sum;
         end
      end else begin : g_two_add
         logic [DW-1:0] inc;
         logic [DW-1:0] dec;
         always_comb begin
            inc    = base_i + step_i;
            dec    = base_i - step_i;
            ea_o   = is_pre ? dec : base_i;
            next_o = is_pre ? dec : inc;
         end
      end
   endgenerate
endmodule

// File: rtl/eag_regfile.sv
module eag_regfile #(
   parameter int DW   = 32,
   parameter int NREG = 16,
   localparam int IW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [IW-1:0] rd_idx_i,
   output logic [DW-1:0] rd_data_o,
   input  logic          upd_en_i,
   input  logic [IW-1:0] upd_idx_i,
   input  logic [DW-1:0] upd_data_i,
   input  logic          ld_en_i,
   input  logic [IW-1:0] ld_idx_i,
   input  logic [DW-1:0] ld_data_i
);
   logic [DW-1:0] regs [NREG];

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_reg
         logic hit_upd;
         logic hit_ld;
         assign hit_upd = upd_en_i && (upd_idx_i == IW'(g));
         assign hit_ld  = ld_en_i  && (ld_idx_i  == IW'(g));
         always_ff @(posedge clk) begin
            if (rst)          regs[g] <= '0;
            else if (hit_upd) regs[g] <= upd_data_i;
            else if (hit_ld)  regs[g] <= ld_data_i;
         end
      end
   endgenerate

   assign rd_data_o = regs[rd_idx_i];
endmodule

// File: rtl/eag_unit.sv
module eag_unit #(
   parameter int DW           = 32,
   parameter int NREG         = 16,
   parameter bit SHARED_ADDER = 1'b1,
   parameter int STEP_STYLE   = 0,
   localparam int IW          = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          exec_i,
   input  logic [1:0]    mode_i,
   input  logic [IW-1:0] idx_i,
   input  logic [1:0]    size_i,
   input  logic          ld_en_i,
   input  logic [IW-1:0] ld_idx_i,
   input  logic [DW-1:0] ld_data_i,
   output logic [DW-1:0] ea_o,
   output logic          reg_op_o,
   output logic          wb_en_o,
   output logic [IW-1:0] wb_idx_o,
   output logic [DW-1:0] wb_data_o
);
   generate
      if (DW < 8)                 begin : g_bad_dw   $error("DW must be at least 8"); end
      if (NREG < 2)               begin : g_bad_nreg $error("NREG must be at least 2"); end
      if ((1 << IW) != NREG)      begin : g_bad_pow2 $error("NREG must be a power of two"); end
      if (STEP_STYLE > 1)         begin : g_bad_sty  $error("STEP_STYLE must be 0 or 1"); end
   endgenerate

   logic [DW-1:0] base;
   logic [DW-1:0] step;
   logic [DW-1:0] next_val;
   logic          modify;

   eag_regfile #(.DW(DW), .NREG(NREG)) u_rf (
      .clk       (clk),
      .rst       (rst),
      .rd_idx_i  (idx_i),
      .rd_data_o (base),
      .upd_en_i  (wb_en_o),
      .upd_idx_i (wb_idx_o),
      .upd_data_i(wb_data_o),
      .ld_en_i   (ld_en_i),
      .ld_idx_i  (ld_idx_i),
      .ld_data_i (ld_data_i)
   );

   eag_step #(.DW(DW), .STEP_STYLE(STEP_STYLE)) u_step (
      .size_i(size_i),
      .step_o(step)
   );

   eag_calc #(.DW(DW), .SHARED_ADDER(SHARED_ADDER)) u_calc (
      .mode_i  (mode_i),
      .base_i  (base),
      .step_i  (step),
      .ea_o    (ea_o),
      .next_o  (next_val),
      .modify_o(modify),
      .reg_op_o(reg_op_o)
   );

   assign wb_en_o   = exec_i && modify;
   assign wb_idx_o  = idx_i;
   assign wb_data_o = next_val;
endmodule

// File: rtl/eag_unit_chk.sv
module eag_unit_chk #(
   parameter int DW = 32,
   parameter int IW = 4
) (
   input logic          clk,
   input logic          rst,
   input logic          exec_i,
   input logic [1:0]    mode_i,
   input logic [IW-1:0] idx_i,
   input logic [1:0]    size_i,
   input logic [DW-1:0] ea_o,
   input logic          reg_op_o,
   input logic          wb_en_o,
   input logic [IW-1:0] wb_idx_o,
   input logic [DW-1:0] wb_data_o
);
   logic [DW-1:0] chk_step;
   assign chk_step = (size_i == 2'b00) ? DW'(1) : (size_i == 2'b01) ? DW'(2) : DW'(4);

   p_direct_flag_r1: assert property (@(posedge clk) disable iff (rst)
      (mode_i == 2'b00) |-> (reg_op_o && !wb_en_o));

   p_indirect_quiet_r2: assert property (@(posedge clk) disable iff (rst)
      (mode_i == 2'b01) |-> (!reg_op_o && !wb_en_o));

   p_postinc_r3: assert property (@(posedge clk) disable iff (rst)
      (exec_i && mode_i == 2'b10) |-> (wb_en_o && wb_idx_o == idx_i && (wb_data_o - ea_o) == chk_step));

   p_predec_r4: assert property (@(posedge clk) disable iff (rst)
      (exec_i && mode_i == 2'b11) |-> (wb_en_o && wb_idx_o == idx_i && wb_data_o == ea_o));

   p_wb_lands_r3: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(wb_en_o) && mode_i == 2'b01 && idx_i == $past(wb_idx_o))
      |-> (ea_o == $past(wb_data_o)));

   p_idle_r7: assert property (@(posedge clk) disable iff (rst)
      !exec_i |-> !wb_en_o);

   p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && mode_i == 2'b01) |-> (ea_o == '0));
endmodule

bind eag_unit eag_unit_chk #(.DW(DW), .IW(IW)) u_chk (
   .clk(clk), .rst(rst), .exec_i(exec_i), .mode_i(mode_i), .idx_i(idx_i),
   .size_i(size_i), .ea_o(ea_o), .reg_op_o(reg_op_o), .wb_en_o(wb_en_o),
   .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o)
);

// File: tb/sim_eag_unit.sv
module sim_eag_unit;
   logic        clk = 1'b0;
   logic        rst;
   logic        exec_i;
   logic [1:0]  mode_i;
   logic [3:0]  idx_i;
   logic [1:0]  size_i;
   logic        ld_en_i;
   logic [3:0]  ld_idx_i;
   logic [31:0] ld_data_i;
   logic [31:0] ea_o;
   logic        reg_op_o;
   logic        wb_en_o;
   logic [3:0]  wb_idx_o;
   logic [31:0] wb_data_o;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   eag_unit u0 (
      .clk(clk), .rst(rst), .exec_i(exec_i), .mode_i(mode_i), .idx_i(idx_i),
      .size_i(size_i), .ld_en_i(ld_en_i), .ld_idx_i(ld_idx_i), .ld_data_i(ld_data_i),
      .ea_o(ea_o), .reg_op_o(reg_op_o), .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o),
      .wb_data_o(wb_data_o)
   );

   typedef struct packed {
      logic [1:0]  m;
      logic [3:0]  idx;
      logic [1:0]  sz;
      logic [31:0] ea;
      logic        rop;
      logic        wbe;
      logic [31:0] wbd;
   } vec_t;

   // mode 00 dir, 01 ind, 10 post, 11 pre; size 00 b, 01 w, 10 l, 11 -> l
   localparam vec_t VEC [16] = '{
      '{2'b00, 4'd1, 2'b10, 32'h0000_1000, 1'b1, 1'b0, 32'h0},          // R1
      '{2'b01, 4'd1, 2'b00, 32'h0000_1000, 1'b0, 1'b0, 32'h0},          // R2
      '{2'b10, 4'd1, 2'b00, 32'h0000_1000, 1'b0, 1'b1, 32'h0000_1001},  // R3 R5
      '{2'b10, 4'd1, 2'b01, 32'h0000_1001, 1'b0, 1'b1, 32'h0000_1003},  // R3 R5
      '{2'b10, 4'd1, 2'b10, 32'h0000_1003, 1'b0, 1'b1, 32'h0000_1007},  // R3 R5
      '{2'b01, 4'd1, 2'b10, 32'h0000_1007, 1'b0, 1'b0, 32'h0},          // R3 landed
      '{2'b11, 4'd2, 2'b00, 32'h0000_1FFF, 1'b0, 1'b1, 32'h0000_1FFF},  // R4
      '{2'b11, 4'd2, 2'b01, 32'h0000_1FFD, 1'b0, 1'b1, 32'h0000_1FFD},  // R4
      '{2'b11, 4'd2, 2'b10, 32'h0000_1FF9, 1'b0, 1'b1, 32'h0000_1FF9},  // R4
      '{2'b11, 4'd2, 2'b11, 32'h0000_1FF5, 1'b0, 1'b1, 32'h0000_1FF5},  // R5 code 11
      '{2'b10, 4'd3, 2'b10, 32'hFFFF_FFFF, 1'b0, 1'b1, 32'h0000_0003},  // R6
      '{2'b01, 4'd3, 2'b00, 32'h0000_0003, 1'b0, 1'b0, 32'h0},          // R6
      '{2'b11, 4'd4, 2'b10, 32'hFFFF_FFFD, 1'b0, 1'b1, 32'hFFFF_FFFD},  // R6
      '{2'b01, 4'd4, 2'b00, 32'hFFFF_FFFD, 1'b0, 1'b0, 32'h0},          // R6
      '{2'b10, 4'd5, 2'b11, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0004},  // R5 code 11
      '{2'b01, 4'd5, 2'b00, 32'h0000_0004, 1'b0, 1'b0, 32'h0}           // R5
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic ex, input logic [1:0] m, input logic [3:0] ix,
                        input logic [1:0] sz);
      @(negedge clk);
      exec_i = ex; mode_i = m; idx_i = ix; size_i = sz;
      ld_en_i = 1'b0;
      #1;
   endtask

   task automatic load(input logic [3:0] ix, input logic [31:0] d);
      @(negedge clk);
      exec_i = 1'b0; mode_i = 2'b01;
      ld_en_i = 1'b1; ld_idx_i = ix; ld_data_i = d;
      @(negedge clk);
      ld_en_i = 1'b0;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      rst = 1'b1; exec_i = 1'b0; mode_i = 2'b01; idx_i = '0; size_i = '0;
      ld_en_i = 1'b0; ld_idx_i = '0; ld_data_i = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R8: every register reads zero after reset
      for (int i = 0; i < 16; i++) begin
         drive(1'b0, 2'b01, 4'(i), 2'b00);
         check("R8 reset clear", ea_o, 32'h0);
      end

      load(4'd1, 32'h0000_1000);
      load(4'd2, 32'h0000_2000);
      load(4'd3, 32'hFFFF_FFFF);
      load(4'd4, 32'h0000_0001);

      for (int v = 0; v < 16; v++) begin
         drive(1'b1, VEC[v].m, VEC[v].idx, VEC[v].sz);
         check($sformatf("R1-R6 vec%0d ea", v), ea_o, VEC[v].ea);
         check($sformatf("R1 vec%0d reg_op", v), {31'b0, reg_op_o}, {31'b0, VEC[v].rop});
         check($sformatf("R3/R4 vec%0d wb_en", v), {31'b0, wb_en_o}, {31'b0, VEC[v].wbe});
         if (VEC[v].wbe) begin
            check($sformatf("R3/R4 vec%0d wb_data", v), wb_data_o, VEC[v].wbd);
            check($sformatf("R3 vec%0d wb_idx", v), {28'b0, wb_idx_o}, {28'b0, VEC[v].idx});
         end
      end

      // R7: strobe low, post-increment must not write
      drive(1'b0, 2'b10, 4'd1, 2'b10);
      check("R7 wb_en low", {31'b0, wb_en_o}, 32'h0);
      drive(1'b0, 2'b11, 4'd1, 2'b10);
      check("R7 wb_en low predec", {31'b0, wb_en_o}, 32'h0);
      drive(1'b0, 2'b01, 4'd1, 2'b00);
      check("R7 register unchanged", ea_o, 32'h0000_1007);

      // R1: direct mode on a register after wrap
      drive(1'b1, 2'b00, 4'd3, 2'b00);
      check("R1 direct contents", ea_o, 32'h0000_0003);

      // R9: collision on the same register, auto-update wins
      @(negedge clk);
      exec_i = 1'b1; mode_i = 2'b10; idx_i = 4'd6; size_i = 2'b10;
      ld_en_i = 1'b1; ld_idx_i = 4'd6; ld_data_i = 32'h0000_0055;
      #1;
      check("R9 collision ea", ea_o, 32'h0);
      drive(1'b0, 2'b01, 4'd6, 2'b00);
      check("R9 auto-update wins", ea_o, 32'h0000_0004);

      // R9: load to a different register in the same cycle lands
      @(negedge clk);
      exec_i = 1'b1; mode_i = 2'b10; idx_i = 4'd6; size_i = 2'b00;
      ld_en_i = 1'b1; ld_idx_i = 4'd7; ld_data_i = 32'h0000_ABCD;
      #1;
      drive(1'b0, 2'b01, 4'd6, 2'b00);
      check("R9 update beside load", ea_o, 32'h0000_0005);
      drive(1'b0, 2'b01, 4'd7, 2'b00);
      check("R9 other load lands", ea_o, 32'h0000_ABCD);

      // R8: reset again clears loaded registers
      @(negedge clk);
      rst = 1'b1; exec_i = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      drive(1'b0, 2'b01, 4'd7, 2'b00);
      check("R8 reclear r7", ea_o, 32'h0);
      drive(1'b0, 2'b01, 4'd1, 2'b00);
      check("R8 reclear r1", ea_o, 32'h0);

      finish_run();
   end
endmodule